// File: doc/BRIEF.md
# Guarded overflow-interrupt enable register

This block holds the 32 overflow-interrupt enable bits of a performance monitor and lets software clear them through a coprocessor-style access port. Each access carries its encoding fields, a read/write flag, write data and the privilege level (0 to 3) of the requester. Alongside it come the trap controls of the two upper privilege levels and the debug state. From these the block picks one of four outcomes: complete the access, raise an undefined-instruction condition, trap to level 2, or trap to level 3. The outcome is reported one cycle later.

A completed write clears every enable whose write-data bit is 1. A completed read returns the enable vector. A separate set port turns enables on, and it stands in for the companion enable-set register. The enables are ANDed with a per-counter overflow vector, and the result is OR-reduced into a single registered interrupt line. Bit 31 belongs to the cycle counter. Bit m, for m from 0 to 30, belongs to event counter m.

Top module: `pmon_irq_enable`

## Requirements
- R1: A response appears only when `acc_valid` is high and the encoding is exactly coprocessor 15, opc1 0, CRn 9, CRm 14, opc2 2. This encoding serves both reads and writes. Any other encoding yields no response (`resp_valid` stays 0) and leaves the enables unchanged.
- R2: `acc_lvl` carries the privilege level as its binary value. An access from level 0 is always undefined.
- R3: At level 1 the checks below are tried in order, and the first that matches decides the outcome.
  - First: halted, level 3 present in 64-bit mode, the debug self-off bit set, the priority option on and the level-3 monitor trap set give undefined.
  - Second: level 2 enabled with its coprocessor-group trap set gives a trap to level 2.
  - Third: level 2 enabled with its monitor trap set gives a trap to level 2.
  - Fourth: level 3 present in 64-bit mode with its monitor trap set gives undefined when halted with the debug self-off bit set, and a trap to level 3 otherwise.
  - If no check matches, the access completes.
- R4: At level 2 only the two level-3 checks of R3 apply, in the same relative order.
- R5: An access at level 3 always completes.
- R6: Every trap reports `resp_ec` = 0x03, and every other outcome reports 0. `resp_narrow_form` is 1 only for a trap to level 2 while level 2 runs in 32-bit mode.
- R7: A completed write clears each enable whose data bit is 1 and leaves the enables under 0 bits as they were.
- R8: A completed read returns the enable vector on `resp_rdata` one cycle after the access. Bit 31 is the cycle counter and bit m is event counter m.
- R9: An undefined or trapped write leaves the enables unchanged. An undefined or trapped read returns zero.
- R10: A 1 on `set_mask` sets that enable at the next edge. When set and clear hit the same bit in one cycle, the clear wins.
- R11: `irq_out` is the registered OR over all bits of (enable AND `ovf_flags`). It follows the inputs one clock later.
- R12: After reset all enables, `irq_out` and `resp_valid` are 0.
- R13: `resp_status` is one-hot while `resp_valid` is 1 and zero otherwise. Bit 0 means complete, bit 1 undefined, bit 2 trap to level 2 and bit 3 trap to level 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_cp | input | 4 | Coprocessor number |
| acc_opc1 | input | 3 | First opcode field |
| acc_crn | input | 4 | Primary register field |
| acc_crm | input | 4 | Secondary register field |
| acc_opc2 | input | 3 | Second opcode field |
| acc_wdata | input | 32 | Write data, 1 bits clear enables |
| acc_lvl | input | 2 | Privilege level of the requester |
| dbg_halted | input | 1 | Core is in debug halt |
| dbg_self_off | input | 1 | Self-hosted debug disabled |
| lvl3_present | input | 1 | Level 3 implemented |
| lvl3_narrow | input | 1 | Level 3 runs in 32-bit mode |
| lvl3_pm_trap | input | 1 | Level 3 traps monitor register access |
| lvl2_on | input | 1 | Level 2 enabled |
| lvl2_narrow | input | 1 | Level 2 runs in 32-bit mode |
| lvl2_cp_trap | input | 1 | Level 2 traps this coprocessor register group |
| lvl2_pm_trap | input | 1 | Level 2 traps monitor register access |
| set_mask | input | 32 | 1 bits set enables |
| ovf_flags | input | 32 | Per-counter overflow flags |
| resp_valid | output | 1 | Response for the previous cycle's access |
| resp_status | output | 4 | One-hot outcome |
| resp_rdata | output | 32 | Read data |
| resp_ec | output | 6 | Syndrome class on traps |
| resp_narrow_form | output | 1 | Level-2 trap goes to a 32-bit handler |
| irq_out | output | 1 | Registered overflow interrupt |

## Verification
The assertions assume that the trap controls and the privilege level stay stable during any cycle in which `acc_valid` is high. They also assume that a blocked write's "no change" claim is judged only in cycles where `set_mask` is zero. The stimulus drives every access for exactly one cycle, starting at a falling edge. It changes the control vector only between accesses and pulses the set port on its own except in the deliberate race case. Together these let the priority chain be swept exhaustively over all control combinations at every level.

// File: rtl/pmon_irq_pkg.sv
package pmon_irq_pkg;

  typedef enum logic [1:0] {
    OUT_DONE  = 2'd0,
    OUT_UNDEF = 2'd1,
    OUT_TRAP2 = 2'd2,
    OUT_TRAP3 = 2'd3
  } outcome_e;

  typedef enum logic [1:0] {
    LVL_0 = 2'd0,
    LVL_1 = 2'd1,
    LVL_2 = 2'd2,
    LVL_3 = 2'd3
  } priv_lvl_e;

  typedef struct packed {
    logic halted;
    logic self_off;
    logic l3_here;
    logic l3_narrow;
    logic l3_pm;
    logic l2_on;
    logic l2_narrow;
    logic l2_cp;
    logic l2_pm;
  } trap_ctl_t;

  // one-hot report code: bit index equals the outcome value
  function automatic logic [3:0] outcome_onehot(input outcome_e o);
    return 4'(4'b0001 << o);
  endfunction

  function automatic logic is_trap(input outcome_e o);
    return (o == OUT_TRAP2) || (o == OUT_TRAP3);
  endfunction

  // level 3 monitor trap is live only when that level exists in 64-bit mode
  function automatic logic l3_pm_live(input trap_ctl_t c);
    return c.l3_here && !c.l3_narrow && c.l3_pm;
  endfunction

  // new enable bit: set first, clear on top so clear wins
  function automatic logic next_enable(input logic cur, input logic set, input logic clr);
    return (cur | set) & ~clr;
  endfunction

endpackage

// File: rtl/pmon_acc_decode.sv
module pmon_acc_decode #(
  parameter int CP_NUM   = 15,
  parameter int OPC1_NUM = 0,
  parameter int CRN_NUM  = 9,
  parameter int CRM_NUM  = 14,
  parameter int OPC2_NUM = 2
) (
  input  logic       valid,
  input  logic [3:0] cp,
  input  logic [2:0] opc1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] opc2,
  output logic       hit
);

  logic cp_ok, opc1_ok, crn_ok, crm_ok, opc2_ok;

  always_comb begin
    cp_ok   = (cp   == 4'(CP_NUM));
    opc1_ok = (opc1 == 3'(OPC1_NUM));
    crn_ok  = (crn  == 4'(CRN_NUM));
    crm_ok  = (crm  == 4'(CRM_NUM));
    opc2_ok = (opc2 == 3'(OPC2_NUM));
    hit     = valid && cp_ok && opc1_ok && crn_ok && crm_ok && opc2_ok;
  end

endmodule

// File: rtl/pmon_priv_arbiter.sv
module pmon_priv_arbiter
  import pmon_irq_pkg::*;
#(
  parameter bit L3_PRIO_FIRST = 1'b1
) (
  input  priv_lvl_e lvl,
  input  trap_ctl_t ctl,
  output outcome_e  outcome,
  output logic      narrow_form
);

  logic dbg_block;
  logic l3_pm_hit;
  logic l2_cp_hit;
  logic l2_pm_hit;
  logic l3_pm_undef;

  always_comb begin
    l3_pm_hit   = l3_pm_live(ctl);
    dbg_block   = ctl.halted && ctl.self_off;
    // early undefined check: needs the priority option and a live level-3 trap
    l3_pm_undef = L3_PRIO_FIRST && dbg_block && l3_pm_hit;
    l2_cp_hit   = ctl.l2_on && ctl.l2_cp;
    l2_pm_hit   = ctl.l2_on && ctl.l2_pm;
  end

  always_comb begin
    outcome = OUT_DONE;
    unique case (lvl)
      LVL_0: outcome = OUT_UNDEF;
      LVL_1: begin
        if (l3_pm_undef)    outcome = OUT_UNDEF;
        else if (l2_cp_hit) outcome = OUT_TRAP2;
        else if (l2_pm_hit) outcome = OUT_TRAP2;
        else if (l3_pm_hit) outcome = dbg_block ? OUT_UNDEF : OUT_TRAP3;
        else                outcome = OUT_DONE;
      end
      LVL_2: begin
        if (l3_pm_undef)    outcome = OUT_UNDEF;
        else if (l3_pm_hit) outcome = dbg_block ? OUT_UNDEF : OUT_TRAP3;
        else                outcome = OUT_DONE;
      end
      LVL_3: outcome = OUT_DONE;
      default: outcome = OUT_UNDEF;
    endcase
    narrow_form = (outcome == OUT_TRAP2) && ctl.l2_narrow;
  end

endmodule

// File: rtl/pmon_inten_bank.sv
module pmon_inten_bank
  import pmon_irq_pkg::*;
#(
  parameter int NBITS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] set_bits,
  input  logic [NBITS-1:0] clr_bits,
  output logic [NBITS-1:0] en_q
);

  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= next_enable(q, set_bits[b], clr_bits[b]);
    end
    assign en_q[b] = q;
  end

endmodule

// File: rtl/pmon_irq_merge.sv
module pmon_irq_merge #(
  parameter int NBITS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] en,
  input  logic [NBITS-1:0] ovf,
  output logic             any_hit,
  output logic             irq_q
);

  always_comb any_hit = |(en & ovf);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_hit;
  end

endmodule

// File: rtl/pmon_irq_enable.sv
module pmon_irq_enable
  import pmon_irq_pkg::*;
#(
  parameter int NUM_EVT       = 31,
  parameter int CP_NUM        = 15,
  parameter int OPC1_NUM      = 0,
  parameter int CRN_NUM       = 9,
  parameter int CRM_NUM       = 14,
  parameter int OPC2_NUM      = 2,
  parameter bit L3_PRIO_FIRST = 1'b1,
  parameter int TRAP_EC       = 3,
  localparam int NBITS        = NUM_EVT + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [3:0]       acc_cp,
  input  logic [2:0]       acc_opc1,
  input  logic [3:0]       acc_crn,
  input  logic [3:0]       acc_crm,
  input  logic [2:0]       acc_opc2,
  input  logic [NBITS-1:0] acc_wdata,
  input  logic [1:0]       acc_lvl,
  input  logic             dbg_halted,
  input  logic             dbg_self_off,
  input  logic             lvl3_present,
  input  logic             lvl3_narrow,
  input  logic             lvl3_pm_trap,
  input  logic             lvl2_on,
  input  logic             lvl2_narrow,
  input  logic             lvl2_cp_trap,
  input  logic             lvl2_pm_trap,
  input  logic [NBITS-1:0] set_mask,
  input  logic [NBITS-1:0] ovf_flags,
  output logic             resp_valid,
  output logic [3:0]       resp_status,
  output logic [NBITS-1:0] resp_rdata,
  output logic [5:0]       resp_ec,
  output logic             resp_narrow_form,
  output logic             irq_out
);

  trap_ctl_t        ctl;
  outcome_e         outc;
  logic             narrow_form;
  logic             acc_fire;
  logic             acc_done;
  logic             wr_done;
  logic             rd_done;
  logic [NBITS-1:0] clr_bits;
  logic [NBITS-1:0] en_q;
  logic             any_hit;

  always_comb begin
    ctl.halted    = dbg_halted;
    ctl.self_off  = dbg_self_off;
    ctl.l3_here   = lvl3_present;
    ctl.l3_narrow = lvl3_narrow;
    ctl.l3_pm     = lvl3_pm_trap;
    ctl.l2_on     = lvl2_on;
    ctl.l2_narrow = lvl2_narrow;
    ctl.l2_cp     = lvl2_cp_trap;
    ctl.l2_pm     = lvl2_pm_trap;
  end

  pmon_acc_decode #(
    .CP_NUM  (CP_NUM),
    .OPC1_NUM(OPC1_NUM),
    .CRN_NUM (CRN_NUM),
    .CRM_NUM (CRM_NUM),
    .OPC2_NUM(OPC2_NUM)
  ) u_dec (
    .valid(acc_valid),
    .cp   (acc_cp),
    .opc1 (acc_opc1),
    .crn  (acc_crn),
    .crm  (acc_crm),
    .opc2 (acc_opc2),
    .hit  (acc_fire)
  );

  pmon_priv_arbiter #(
    .L3_PRIO_FIRST(L3_PRIO_FIRST)
  ) u_arb (
    .lvl        (priv_lvl_e'(acc_lvl)),
    .ctl        (ctl),
    .outcome    (outc),
    .narrow_form(narrow_form)
  );

  always_comb begin
    acc_done = acc_fire && (outc == OUT_DONE);
    wr_done  = acc_done && acc_write;
    rd_done  = acc_done && !acc_write;
    clr_bits = wr_done ? acc_wdata : '0;
  end

  pmon_inten_bank #(
    .NBITS(NBITS)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_bits(set_mask),
    .clr_bits(clr_bits),
    .en_q    (en_q)
  );

  pmon_irq_merge #(
    .NBITS(NBITS)
  ) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en_q),
    .ovf    (ovf_flags),
    .any_hit(any_hit),
    .irq_q  (irq_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid       <= 1'b0;
      resp_status      <= '0;
      resp_rdata       <= '0;
      resp_ec          <= '0;
      resp_narrow_form <= 1'b0;
    end else begin
      resp_valid       <= acc_fire;
      resp_status      <= acc_fire ? outcome_onehot(outc) : 4'b0000;
      resp_rdata       <= rd_done ? en_q : '0;
      resp_ec          <= (acc_fire && is_trap(outc)) ? 6'(TRAP_EC) : 6'd0;
      resp_narrow_form <= acc_fire && narrow_form;
    end
  end

endmodule

// File: rtl/pmon_irq_enable_chk.sv
module pmon_irq_enable_chk #(
  parameter int NBITS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_fire,
  input logic             acc_done,
  input logic             acc_write,
  input logic [1:0]       acc_lvl,
  input logic [NBITS-1:0] acc_wdata,
  input logic [NBITS-1:0] set_mask,
  input logic [NBITS-1:0] ovf_flags,
  input logic [NBITS-1:0] en_q,
  input logic             resp_valid,
  input logic [3:0]       resp_status,
  input logic [NBITS-1:0] resp_rdata,
  input logic [5:0]       resp_ec,
  input logic             irq_out
);

  // R13
  status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $countones(resp_status) == 1);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> resp_status == 4'b0000);

  // R2
  lvl0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && acc_lvl == 2'd0) |=> resp_status == 4'b0010);

  // R5
  lvl3_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && acc_lvl == 2'd3) |=> resp_status == 4'b0001);

  // R6
  trap_ec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && (resp_status[2] || resp_status[3])) |-> resp_ec == 6'h03);

  // R9
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && acc_write && !acc_done && set_mask == '0) |=> en_q == $past(en_q));

  // R9
  blocked_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_status[0]) |-> resp_rdata == '0);

  // R10
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && acc_write) |=> (en_q & $past(acc_wdata)) == '0);

  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flags == '0) |=> !irq_out);

endmodule

bind pmon_irq_enable pmon_irq_enable_chk #(.NBITS(NBITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_fire   (acc_fire),
  .acc_done   (acc_done),
  .acc_write  (acc_write),
  .acc_lvl    (acc_lvl),
  .acc_wdata  (acc_wdata),
  .set_mask   (set_mask),
  .ovf_flags  (ovf_flags),
  .en_q       (en_q),
  .resp_valid (resp_valid),
  .resp_status(resp_status),
  .resp_rdata (resp_rdata),
  .resp_ec    (resp_ec),
  .irq_out    (irq_out)
);

// File: tb/pmon_irq_enable_test.sv
module pmon_irq_enable_test;

  localparam bit PRIO = 1'b1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [3:0]  acc_cp = 4'd15, acc_crn = 4'd9, acc_crm = 4'd14;
  logic [2:0]  acc_opc1 = 3'd0, acc_opc2 = 3'd2;
  logic [31:0] acc_wdata = '0;
  logic [1:0]  acc_lvl = 2'd0;
  logic c_halt = 0, c_soff = 0, c_l3 = 0, c_l3n = 0, c_l3pm = 0;
  logic c_l2 = 0, c_l2n = 0, c_l2cp = 0, c_l2pm = 0;
  logic [31:0] set_mask = '0, ovf_flags = '0;
  logic        resp_valid, resp_narrow_form, irq_out;
  logic [3:0]  resp_status;
  logic [31:0] resp_rdata;
  logic [5:0]  resp_ec;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] en_model = '0;

  pmon_irq_enable #(.L3_PRIO_FIRST(PRIO)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_cp(acc_cp), .acc_opc1(acc_opc1), .acc_crn(acc_crn), .acc_crm(acc_crm),
    .acc_opc2(acc_opc2), .acc_wdata(acc_wdata), .acc_lvl(acc_lvl),
    .dbg_halted(c_halt), .dbg_self_off(c_soff), .lvl3_present(c_l3),
    .lvl3_narrow(c_l3n), .lvl3_pm_trap(c_l3pm), .lvl2_on(c_l2),
    .lvl2_narrow(c_l2n), .lvl2_cp_trap(c_l2cp), .lvl2_pm_trap(c_l2pm),
    .set_mask(set_mask), .ovf_flags(ovf_flags), .resp_valid(resp_valid),
    .resp_status(resp_status), .resp_rdata(resp_rdata), .resp_ec(resp_ec),
    .resp_narrow_form(resp_narrow_form), .irq_out(irq_out)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // expected outcome code from the requirement text
  function automatic logic [3:0] ref_status(input int lvl);
    logic l3_live;
    logic blocked;
    l3_live = c_l3 && !c_l3n && c_l3pm;
    blocked = c_halt && c_soff;
    if (lvl == 0) return 4'b0010;
    if (lvl == 3) return 4'b0001;
    if (PRIO && blocked && l3_live) return 4'b0010;
    if (lvl == 1 && c_l2 && (c_l2cp || c_l2pm)) return 4'b0100;
    if (l3_live) return blocked ? 4'b0010 : 4'b1000;
    return 4'b0001;
  endfunction

  // one-cycle access; results are in the resp_* signals on return
  task automatic access(input bit wr, input int lvl, input logic [31:0] wd,
                        input logic [31:0] setm, input int enc_bad);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_write = wr;
    acc_lvl   = 2'(lvl);
    acc_wdata = wd;
    set_mask  = setm;
    acc_cp    = (enc_bad == 1) ? 4'd7  : 4'd15;
    acc_opc1  = (enc_bad == 2) ? 3'd1  : 3'd0;
    acc_crn   = (enc_bad == 3) ? 4'd10 : 4'd9;
    acc_crm   = (enc_bad == 4) ? 4'd12 : 4'd14;
    acc_opc2  = (enc_bad == 5) ? 3'd1  : 3'd2;
    @(negedge clk);
    acc_valid = 1'b0;
    acc_write = 1'b0;
    acc_wdata = '0;
    set_mask  = '0;
    acc_cp = 4'd15; acc_opc1 = 3'd0; acc_crn = 4'd9; acc_crm = 4'd14; acc_opc2 = 3'd2;
  endtask

  task automatic read_en(input string req);
    access(1'b0, 3, '0, '0, 0);
    chk(req, "enable readback", resp_rdata, en_model);
  endtask

  task automatic ctl_clear();
    {c_halt, c_soff, c_l3, c_l3n, c_l3pm, c_l2, c_l2n, c_l2cp, c_l2pm} = '0;
  endtask

  task automatic t_reset();
    chk("R12", "resp_valid after reset", 32'(resp_valid), 0);
    chk("R12", "irq after reset", 32'(irq_out), 0);
    read_en("R12");
    chk("R5", "level 3 read status", 32'(resp_status), 32'h1);
    chk("R13", "resp_valid on hit", 32'(resp_valid), 1);
  endtask

  task automatic t_set_clear();
    access(1'b0, 3, '0, 32'hFFFF_FFFF, 0);
    chk("R8", "read in set cycle returns old value", resp_rdata, 32'h0);
    en_model = 32'hFFFF_FFFF;
    read_en("R10");
    access(1'b1, 3, 32'h8000_00F0, '0, 0);
    chk("R7", "write status", 32'(resp_status), 32'h1);
    en_model = 32'h7FFF_FF0F;
    read_en("R7");
    access(1'b1, 3, 32'h0, '0, 0);
    read_en("R7");
  endtask

  task automatic t_race();
    access(1'b1, 3, 32'hFFFF_FFFF, '0, 0);
    en_model = '0;
    access(1'b1, 3, 32'h0000_0005, 32'h0000_0007, 0);
    en_model = 32'h0000_0002;
    read_en("R10");
  endtask

  task automatic t_decode();
    access(1'b0, 3, '0, 32'h0000_1100, 0);
    en_model = en_model | 32'h0000_1100;
    for (int f = 1; f <= 5; f++) begin
      access(1'b1, 3, 32'hFFFF_FFFF, '0, f);
      chk("R1", $sformatf("no response for bad field %0d", f), 32'(resp_valid), 0);
      chk("R1", "no status for bad encoding", 32'(resp_status), 0);
      read_en("R1");
    end
  endtask

  task automatic t_lvl0();
    ctl_clear();
    access(1'b0, 0, '0, '0, 0);
    chk("R2", "level 0 read", 32'(resp_status), 32'h2);
    chk("R9", "level 0 read data", resp_rdata, 0);
    access(1'b1, 0, 32'hFFFF_FFFF, '0, 0);
    chk("R2", "level 0 write", 32'(resp_status), 32'h2);
    read_en("R9");
  endtask

  task automatic t_blocked_write();
    ctl_clear();
    c_l2 = 1; c_l2cp = 1; c_l2n = 1;
    access(1'b1, 1, 32'hFFFF_FFFF, '0, 0);
    chk("R3", "level 2 trap on write", 32'(resp_status), 32'h4);
    chk("R6", "narrow form", 32'(resp_narrow_form), 1);
    read_en("R9");
    ctl_clear();
    c_l3 = 1; c_l3pm = 1;
    access(1'b1, 2, 32'hFFFF_FFFF, '0, 0);
    chk("R4", "level 3 trap from level 2", 32'(resp_status), 32'h8);
    chk("R6", "level 3 trap ec", 32'(resp_ec), 3);
    read_en("R9");
    ctl_clear();
  endtask

  task automatic t_sweep();
    for (int lvl = 0; lvl < 4; lvl++) begin
      for (int k = 0; k < 512; k++) begin
        logic [3:0] exp_s;
        logic [8:0] kb;
        kb = 9'(k);
        {c_halt, c_soff, c_l3, c_l3n, c_l3pm, c_l2, c_l2n, c_l2cp, c_l2pm} = kb;
        exp_s = ref_status(lvl);
        access(1'b0, lvl, '0, '0, 0);
        chk(lvl == 1 ? "R3" : (lvl == 2 ? "R4" : (lvl == 0 ? "R2" : "R5")),
            $sformatf("status lvl %0d ctl %h", lvl, k), 32'(resp_status), 32'(exp_s));
        chk("R6", "syndrome class", 32'(resp_ec), (exp_s[2] || exp_s[3]) ? 32'h3 : 32'h0);
        chk("R6", "narrow form flag", 32'(resp_narrow_form), 32'(exp_s[2] && c_l2n));
        chk(exp_s[0] ? "R8" : "R9", "read data", resp_rdata, exp_s[0] ? en_model : 32'h0);
      end
    end
    ctl_clear();
  endtask

  task automatic t_irq();
    access(1'b1, 3, 32'hFFFF_FFFF, '0, 0);
    en_model = '0;
    @(negedge clk);
    ovf_flags = 32'h0000_0020;
    @(negedge clk);
    chk("R11", "masked overflow", 32'(irq_out), 0);
    set_mask = 32'h0000_0020;
    @(negedge clk);
    set_mask = '0;
    chk("R11", "irq one cycle behind enable", 32'(irq_out), 0);
    @(negedge clk);
    chk("R11", "irq raised", 32'(irq_out), 1);
    ovf_flags = '0;
    @(negedge clk);
    chk("R11", "irq dropped", 32'(irq_out), 0);
    set_mask = 32'h8000_0000;
    ovf_flags = 32'h8000_0000;
    @(negedge clk);
    set_mask = '0;
    @(negedge clk);
    chk("R11", "cycle counter irq", 32'(irq_out), 1);
    ovf_flags = '0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL all watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_clear();
    t_race();
    t_decode();
    t_lvl0();
    t_blocked_write();
    t_sweep();
    t_irq();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule